// File: doc/BRIEF.md
# Toggle-Based Horizontal Blanking Generator

This block produces the horizontal blanking window of an image-sensor readout line and uses it to freeze a complementary pair of horizontal transfer clocks. A pixel counter starts at zero in the cycle after a line-start strobe. A bank of six programmable toggle positions inverts the blanking level each time the counter passes one of them. Two positions give the usual single blanking interval. With all six in use, two extra bursts of clock pulses appear inside that interval.

While blanking is active, the first clock output is held at a programmable level and the second at the opposite level. At all other times both outputs carry the incoming clocks unchanged. An external blanking input, with a polarity control of its own, can take the place of the internal generator. The hold level chosen by the mask polarity applies in both modes. The block does not produce the clocks it gates, and it has no register access of its own.

Top module: `hblank_toggle_gen`

## Requirements
- R1: After reset, with the external select low, `blank_o` is 0 and the two clock outputs equal `hclk_a` and `hclk_b`.
- R2: A one-cycle `line_start` pulse places the line at pixel 0 in the following cycle, and internal blanking is inactive at pixel 0 whatever its earlier state.
- R3: During pixel p of a line, internal blanking equals the XOR, over the active toggle positions, of (position < p). A toggle at position q changes the level from pixel q+1 onward.
- R4: Two or more active toggles at the same position act by parity. An even number of them leaves the level unchanged.
- R5: A toggle position equal to all ones (8191), or greater than or equal to `LINE_PIXELS`, never changes the level.
- R6: After the last pixel (`LINE_PIXELS`-1) the counter stops, and internal blanking holds its final value until the next `line_start`.
- R7: While `blank_o` is 1, `h_a_o` equals `mask_pol` and `h_b_o` equals its inverse.
- R8: While `blank_o` is 0, `h_a_o` equals `hclk_a` and `h_b_o` equals `hclk_b`.
- R9: With `ext_sel` = 1 the internal generator is ignored, and `blank_o` is 1 exactly when `ext_blank` equals `ext_pol` (`ext_pol` = 1 means active high). R7 and R8 still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | One-cycle strobe that starts a new line |
| tog_pos | input | 6x13 | Toggle positions, in pixel counts |
| mask_pol | input | 1 | Held level of `h_a_o` while blanking |
| ext_sel | input | 1 | 1 selects the external blanking input |
| ext_blank | input | 1 | External blanking input |
| ext_pol | input | 1 | Active level of `ext_blank` |
| hclk_a | input | 1 | Incoming first horizontal clock |
| hclk_b | input | 1 | Incoming second (complementary) horizontal clock |
| blank_o | output | 1 | Effective blanking signal |
| h_a_o | output | 1 | Gated first horizontal clock |
| h_b_o | output | 1 | Gated second horizontal clock |

## Verification
The assertions assume that `line_start` is a single-cycle pulse and that the toggle positions and the polarity controls stay constant for the whole of a line. The bench changes configuration only in the cycles between lines. The output properties also assume that the two incoming clocks are complementary, so the stimulus always drives `hclk_b` as the inverse of `hclk_a`, and it changes `ext_blank` only on the falling clock edge.

// File: rtl/hbk_pkg.sv
package hbk_pkg;

    localparam int POS_W   = 13;
    localparam int NUM_TOG = 6;

    typedef logic [POS_W-1:0] pos_t;

    // Pixel counter state: valid while the line is running
    typedef struct packed {
        logic valid;
        pos_t pix;
    } pix_state_t;

    // Gated output bundle
    typedef struct packed {
        logic blank;
        logic a;
        logic b;
    } hout_t;

    // A position takes part only if it is not all ones and lies inside the line
    function automatic logic pos_usable(pos_t p, int unsigned line_len);
        return (p != '1) && (32'(p) < line_len);
    endfunction

endpackage

// File: rtl/hbk_pix_counter.sv
module hbk_pix_counter
    import hbk_pkg::*;
#(
    parameter int LINE_PIXELS = 4000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_start,
    output pix_state_t st
);

    localparam pos_t LAST = pos_t'(LINE_PIXELS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (line_start) begin
            st.valid <= 1'b1;
            st.pix   <= '0;
        end else if (st.valid) begin
            if (st.pix == LAST) begin
                st.valid <= 1'b0;
            end else begin
                st.pix <= st.pix + pos_t'(1);
            end
        end
    end

    // R2: the strobe puts the line at pixel zero
    a_r2_start_zero: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (st.valid && st.pix == '0));

    // R3: a running counter never leaves the line
    a_r3_pix_range: assert property (@(posedge clk) disable iff (rst)
        st.valid |-> (st.pix <= LAST));

    // R6: once finished, the counter stays put until the next strobe
    a_r6_counter_stops: assert property (@(posedge clk) disable iff (rst)
        (!st.valid && !line_start) |=> (!st.valid && $stable(st.pix)));

endmodule

// File: rtl/hbk_toggle_bank.sv
module hbk_toggle_bank
    import hbk_pkg::*;
#(
    parameter int LINE_PIXELS = 4000,
    parameter int NUM_TOG     = hbk_pkg::NUM_TOG
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          line_start,
    input  pix_state_t                    st,
    input  logic [NUM_TOG-1:0][POS_W-1:0] tog_pos,
    output logic                          blk
);

    logic [NUM_TOG-1:0] hit;
    logic               flip;

    for (genvar k = 0; k < NUM_TOG; k++) begin : g_cmp
        assign hit[k] = st.valid
                     && pos_usable(pos_t'(tog_pos[k]), LINE_PIXELS)
                     && (pos_t'(tog_pos[k]) == st.pix);
    end

    // Coincident toggles combine by parity
    assign flip = ^hit;

    always_ff @(posedge clk) begin
        if (rst || line_start) begin
            blk <= 1'b0;
        end else if (flip) begin
            blk <= ~blk;
        end
    end

    // R2: a new line always begins outside blanking
    a_r2_line_clear: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !blk);

    // R6: nothing moves the level between lines
    a_r6_hold_after_line: assert property (@(posedge clk) disable iff (rst)
        (!st.valid && !line_start) |=> $stable(blk));

endmodule

// File: rtl/hbk_clock_mask.sv
module hbk_clock_mask
    import hbk_pkg::*;
(
    input  logic  blk_int,
    input  logic  ext_sel,
    input  logic  ext_blank,
    input  logic  ext_pol,
    input  logic  mask_pol,
    input  logic  hclk_a,
    input  logic  hclk_b,
    output hout_t hout
);

    logic eff;

    always_comb begin
        eff        = ext_sel ? (ext_blank == ext_pol) : blk_int;
        hout.blank = eff;
        hout.a     = eff ? mask_pol  : hclk_a;
        hout.b     = eff ? ~mask_pol : hclk_b;
    end

endmodule

// File: rtl/hblank_toggle_gen.sv
module hblank_toggle_gen
    import hbk_pkg::*;
#(
    parameter int LINE_PIXELS = 4000,
    parameter int NUM_TOG     = hbk_pkg::NUM_TOG
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          line_start,
    input  logic [NUM_TOG-1:0][POS_W-1:0] tog_pos,
    input  logic                          mask_pol,
    input  logic                          ext_sel,
    input  logic                          ext_blank,
    input  logic                          ext_pol,
    input  logic                          hclk_a,
    input  logic                          hclk_b,
    output logic                          blank_o,
    output logic                          h_a_o,
    output logic                          h_b_o
);

    pix_state_t st;
    logic       blk_int;
    hout_t      hout;

    hbk_pix_counter #(.LINE_PIXELS(LINE_PIXELS)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .st         (st)
    );

    hbk_toggle_bank #(.LINE_PIXELS(LINE_PIXELS), .NUM_TOG(NUM_TOG)) u_tog (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .st         (st),
        .tog_pos    (tog_pos),
        .blk        (blk_int)
    );

    hbk_clock_mask u_mask (
        .blk_int   (blk_int),
        .ext_sel   (ext_sel),
        .ext_blank (ext_blank),
        .ext_pol   (ext_pol),
        .mask_pol  (mask_pol),
        .hclk_a    (hclk_a),
        .hclk_b    (hclk_b),
        .hout      (hout)
    );

    assign blank_o = hout.blank;
    assign h_a_o   = hout.a;
    assign h_b_o   = hout.b;

    // R7: masked clocks sit at the programmed level and its opposite
    a_r7_mask_levels: assert property (@(posedge clk) disable iff (rst)
        blank_o |-> (h_a_o == mask_pol && h_b_o == ~mask_pol));

    // R8: unmasked clocks pass through
    a_r8_pass_through: assert property (@(posedge clk) disable iff (rst)
        !blank_o |-> (h_a_o == hclk_a && h_b_o == hclk_b));

    // R9: external mode follows the external input
    a_r9_ext_follow: assert property (@(posedge clk) disable iff (rst)
        ext_sel |-> (blank_o == (ext_blank == ext_pol)));

endmodule

// File: tb/sim_hblank_toggle_gen.sv
module sim_hblank_toggle_gen;
    localparam int L  = 40;
    localparam int NT = 6;

    logic clk = 1'b0;
    logic rst, line_start, mask_pol, ext_sel, ext_blank, ext_pol, hclk_a, hclk_b;
    logic [NT-1:0][12:0] tog_pos;
    logic blank_o, h_a_o, h_b_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    hblank_toggle_gen #(.LINE_PIXELS(L), .NUM_TOG(NT)) u0 (
        .clk(clk), .rst(rst), .line_start(line_start), .tog_pos(tog_pos),
        .mask_pol(mask_pol), .ext_sel(ext_sel), .ext_blank(ext_blank),
        .ext_pol(ext_pol), .hclk_a(hclk_a), .hclk_b(hclk_b),
        .blank_o(blank_o), .h_a_o(h_a_o), .h_b_o(h_b_o)
    );

    // Model of R3/R4/R5: parity of active toggles below pixel p
    function automatic logic model_blk(int p);
        logic r = 1'b0;
        for (int k = 0; k < NT; k++) begin
            if (tog_pos[k] != 13'h1FFF && int'(tog_pos[k]) < L && int'(tog_pos[k]) < p)
                r = ~r;
        end
        return r;
    endfunction

    task automatic check(string req, logic [2:0] act, logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b (blank,a,b) at %0t", req, act, exp, $time);
        end
    endtask

    // Drive clocks at pixel p, then compare against the model
    task automatic check_px(string req, int p, logic int_blk);
        logic eff;
        hclk_a    = p[0];
        hclk_b    = ~p[0];
        ext_blank = p[1] ^ p[3];
        #2;
        eff = ext_sel ? (ext_blank == ext_pol) : int_blk;
        check(req, {blank_o, h_a_o, h_b_o},
              {eff, eff ? mask_pol : hclk_a, eff ? ~mask_pol : hclk_b});
    endtask

    // One full line plus a few idle cycles after it
    task automatic run_line(string req);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int p = 0; p < L; p++) begin
            check_px(req, p, model_blk(p));
            @(negedge clk);
        end
        for (int i = 0; i < 3; i++) begin
            check_px("R6", L + i, model_blk(L));
            @(negedge clk);
        end
    endtask

    task automatic set_tog(int t0, int t1, int t2, int t3, int t4, int t5);
        tog_pos[0] = 13'(t0); tog_pos[1] = 13'(t1); tog_pos[2] = 13'(t2);
        tog_pos[3] = 13'(t3); tog_pos[4] = 13'(t4); tog_pos[5] = 13'(t5);
    endtask

    initial begin
        rst = 1'b1; line_start = 1'b0; mask_pol = 1'b0; ext_sel = 1'b0;
        ext_blank = 1'b0; ext_pol = 1'b1; hclk_a = 1'b0; hclk_b = 1'b1;
        set_tog(8191, 8191, 8191, 8191, 8191, 8191);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state, pass-through
        for (int i = 0; i < 4; i++) begin
            check_px("R1", i, 1'b0);
            @(negedge clk);
        end

        // R3 with R7/R8: exhaustive sweep of a two-toggle interval, both mask levels
        for (int a = 0; a < L; a++) begin
            for (int b = 0; b < L; b++) begin
                mask_pol = a[0] ^ b[0];
                set_tog(a, b, 8191, 8191, 8191, 8191);
                run_line("R3");
            end
        end

        // R3: six toggles give extra pulse groups inside the interval
        mask_pol = 1'b1;
        set_tog(5, 9, 12, 16, 19, 30);
        run_line("R3");
        set_tog(30, 0, 19, 5, 39, 12);
        run_line("R3");

        // R2: odd toggle count ends blanked; next line must start clear
        set_tog(10, 8191, 8191, 8191, 8191, 8191);
        run_line("R2");
        run_line("R2");

        // R4: coincident toggles cancel by parity
        set_tog(7, 7, 20, 8191, 8191, 8191);
        run_line("R4");
        set_tog(7, 7, 7, 25, 25, 8191);
        run_line("R4");

        // R5: all ones, exactly the line length, and beyond never fire
        set_tog(8191, L, 100, 4000, 8190, 3);
        run_line("R5");
        set_tog(8191, L, L + 1, 8191, 8191, 8191);
        run_line("R5");

        // R9: external mode, both polarities, both mask levels, internal pattern present
        set_tog(4, 22, 8191, 8191, 8191, 8191);
        ext_sel = 1'b1;
        for (int c = 0; c < 4; c++) begin
            ext_pol  = c[0];
            mask_pol = c[1];
            run_line("R9");
        end
        ext_sel = 1'b0;
        run_line("R8");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule